// File: doc/BRIEF.md
# Fast/Trickle Charge Mode Controller

This block is the supervisory state machine of a battery charger. It decides whether the charger runs in fast mode or in trickle mode. It does not handle analog signals. Window comparators, temperature sensing, the long charge timer and the slope detector all sit outside the block and reach it as synchronous flags. A one-second tick drives an internal holdoff counter. While that counter has not reached its limit, negative-slope reports are discarded, so the voltage dip that stale packs show early in a charge cannot end fast charging.

Trickle causes differ in how they clear. Some are self-clearing:
- sense voltage above the window,
- sense voltage below the window,
- pack too cold.

The charger returns to fast mode once all of these have gone away. Others are held until the next power-on reset:
- pack too hot,
- an accepted negative slope,
- charge timer expiry (by default).

The holdoff counter runs only while the next state is fast. It is cleared whenever the block leaves fast mode, so every return to fast mode starts a fresh holdoff period.

Top module: `chg_mode_ctrl`

## Requirements
- R1: After power-on reset (rst_n low), fast_mode is 1 and holdoff_done is 0.
- R2: v_high or v_low at a clock edge makes fast_mode 0 after that edge. Once both are low again, and no other cause is active, fast_mode returns to 1 after the next edge.
- R3: temp_cold forces fast_mode to 0. It self-clears: fast_mode returns to 1 one edge after temp_cold falls, if no other cause is active.
- R4: temp_hot forces fast_mode to 0. This stays in force until reset, even after temp_hot falls.
- R5: tmr_done forces fast_mode to 0. With TIMER_LATCH=1 (the default), this stays in force until reset.
- R6: slope_det has no effect on fast_mode while holdoff_done is 0.
- R7: slope_det while holdoff_done is 1 and fast_mode is 1 forces fast_mode to 0. This stays in force until reset.
- R8: The holdoff counter advances on each tick_1s edge only while the block is in fast mode. holdoff_done goes to 1 after HOLDOFF_SEC (177) counted ticks and then stays at 1 (saturation). In trickle mode holdoff_done is 0.
- R9: When the block returns to fast mode, the holdoff count restarts from zero. A full HOLDOFF_SEC ticks are then needed before holdoff_done goes to 1.
- R10: When several self-clearing causes are active together, fast_mode stays 0 until the last of them clears.
- R11: A power-on reset clears every latched cause, and fast mode resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick_1s | input | 1 | One-cycle pulse each second |
| v_high | input | 1 | Sense voltage above window (open pack) |
| v_low | input | 1 | Sense voltage below window (shorted cell) |
| temp_hot | input | 1 | Pack above temperature range |
| temp_cold | input | 1 | Pack below temperature range |
| tmr_done | input | 1 | Charge timer expired |
| slope_det | input | 1 | Negative-slope detect pulse |
| fast_mode | output | 1 | 1 = fast charge, 0 = trickle |
| holdoff_done | output | 1 | Slope detection enabled |

## Verification
The hardest state to reach is an accepted negative slope. It needs 177 counted ticks of unbroken fast mode, and any fault during that time clears the count. The stimulus first drives the full tick run from reset with all faults low. It checks holdoff_done at tick 176 and again at tick 177, and only then pulses slope_det. The counter-restart case is reached the same way. A voltage fault partway through the run is held across many ticks, and after it clears the full holdoff period is counted again.

// File: rtl/chg_mode_pkg.sv
package chg_mode_pkg;
   // Charge mode encoding on the fast_mode output
   typedef enum logic {
      MODE_TRICKLE = 1'b0,
      MODE_FAST    = 1'b1
   } chg_mode_e;

   // Index of each held trickle cause in the cause vector
   localparam int unsigned CAUSE_HOT   = 0;
   localparam int unsigned CAUSE_TMR   = 1;
   localparam int unsigned CAUSE_SLOPE = 2;
   localparam int unsigned N_CAUSES    = 3;
endpackage

// File: rtl/chg_cause_latch.sv
module chg_cause_latch #(
   parameter bit STICKY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   output logic active_o
);
   generate
      if (STICKY) begin : g_sticky
         logic held_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) held_q <= 1'b0;
            else if (set_i) held_q <= 1'b1;
         end
         // The cause counts from the cycle it is raised, then stays held
         assign active_o = set_i | held_q;
      end else begin : g_pass
         assign active_o = set_i;
      end
   endgenerate
endmodule

// File: rtl/chg_holdoff_cnt.sv
module chg_holdoff_cnt #(
   parameter int unsigned LIMIT = 177,
   localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic run_i,     // current state is fast
   input  logic keep_i,    // next state is fast
   output logic done_o
);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("chg_holdoff_cnt: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (!keep_i) cnt_q <= '0;
      else if (tick_i && run_i && (cnt_q != LIM)) cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = (cnt_q == LIM);

   // R8: the count never passes its saturation value
   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM);

   // R9: leaving fast mode restarts the count
   a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !keep_i |=> (cnt_q == '0));
endmodule

// File: rtl/chg_mode_ctrl.sv
module chg_mode_ctrl #(
   parameter int unsigned HOLDOFF_SEC = 177,
   parameter bit          TIMER_LATCH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_1s,
   input  logic v_high,
   input  logic v_low,
   input  logic temp_hot,
   input  logic temp_cold,
   input  logic tmr_done,
   input  logic slope_det,
   output logic fast_mode,
   output logic holdoff_done
);
   import chg_mode_pkg::*;

   localparam logic [N_CAUSES-1:0] STICKY_MASK =
      {1'b1, TIMER_LATCH, 1'b1};   // slope, timer, hot

   chg_mode_e          mode_q;
   logic               fast_next;
   logic               self_clr;
   logic               slope_acc;
   logic [N_CAUSES-1:0] cause_set;
   logic [N_CAUSES-1:0] cause_act;

   // A slope report counts only once the holdoff has expired in fast mode
   assign slope_acc = slope_det && holdoff_done && (mode_q == MODE_FAST);

   always_comb begin
      cause_set              = '0;
      cause_set[CAUSE_HOT]   = temp_hot;
      cause_set[CAUSE_TMR]   = tmr_done;
      cause_set[CAUSE_SLOPE] = slope_acc;
   end

   genvar gi;
   generate
      for (gi = 0; gi < N_CAUSES; gi++) begin : g_cause
         chg_cause_latch #(.STICKY(STICKY_MASK[gi])) u_latch (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (cause_set[gi]),
            .active_o (cause_act[gi])
         );
      end
   endgenerate

   assign self_clr  = v_high | v_low | temp_cold;
   assign fast_next = !(self_clr || (|cause_act));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_FAST;
      else        mode_q <= fast_next ? MODE_FAST : MODE_TRICKLE;
   end

   assign fast_mode = (mode_q == MODE_FAST);

   chg_holdoff_cnt #(.LIMIT(HOLDOFF_SEC)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_1s),
      .run_i  (fast_mode),
      .keep_i (fast_next),
      .done_o (holdoff_done)
   );

   // R2: window fault forces trickle on the next cycle
   a_r2_window_trickle: assert property (@(posedge clk) disable iff (!rst_n)
      (v_high || v_low) |=> !fast_mode);
   // R4: hot pack stays in trickle
   a_r4_hot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      temp_hot |=> !fast_mode);
   a_r4_hot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!fast_mode && $past(temp_hot)) |=> !fast_mode);
   // R6: slope before holdoff is ignored when nothing else is active
   a_r6_slope_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (slope_det && !holdoff_done && fast_mode && !v_high && !v_low
       && !temp_hot && !temp_cold && !tmr_done) |=> fast_mode);
   // R8: holdoff complete only while fast
   a_r8_done_in_fast: assert property (@(posedge clk) disable iff (!rst_n)
      holdoff_done |-> fast_mode);
   // R7: accepted slope forces trickle
   a_r7_slope_trickle: assert property (@(posedge clk) disable iff (!rst_n)
      (slope_det && holdoff_done) |=> !fast_mode);
endmodule

// File: tb/tb_chg_mode_ctrl.sv
module tb_chg_mode_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_1s = 1'b0, v_high = 1'b0, v_low = 1'b0;
   logic temp_hot = 1'b0, temp_cold = 1'b0, tmr_done = 1'b0, slope_det = 1'b0;
   logic fast_mode, holdoff_done;
   int n_chk = 0, n_fail = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   chg_mode_ctrl dut (
      .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .v_high(v_high),
      .v_low(v_low), .temp_hot(temp_hot), .temp_cold(temp_cold),
      .tmr_done(tmr_done), .slope_det(slope_det),
      .fast_mode(fast_mode), .holdoff_done(holdoff_done)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      {tick_1s, v_high, v_low, temp_hot, temp_cold, tmr_done, slope_det} = '0;
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_1s = 1'b1; step(1);
         tick_1s = 1'b0; step(1);
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 fast", fast_mode, 1'b1);
      chk("R1 holdoff", holdoff_done, 1'b0);
   endtask

   task automatic t_window();
      do_reset();
      v_high = 1'b1; step(1);
      chk("R2 high", fast_mode, 1'b0);
      v_high = 1'b0; step(1);
      chk("R2 high clear", fast_mode, 1'b1);
      v_low = 1'b1; step(3);
      chk("R2 low", fast_mode, 1'b0);
      v_low = 1'b0; step(1);
      chk("R2 low clear", fast_mode, 1'b1);
   endtask

   task automatic t_cold_hot();
      do_reset();
      temp_cold = 1'b1; step(2);
      chk("R3 cold", fast_mode, 1'b0);
      temp_cold = 1'b0; step(1);
      chk("R3 cold clear", fast_mode, 1'b1);
      temp_hot = 1'b1; step(1);
      chk("R4 hot", fast_mode, 1'b0);
      temp_hot = 1'b0; step(5);
      chk("R4 hot held", fast_mode, 1'b0);
      do_reset();
      chk("R11 hot cleared", fast_mode, 1'b1);
   endtask

   task automatic t_timer();
      do_reset();
      tmr_done = 1'b1; step(1);
      chk("R5 timer", fast_mode, 1'b0);
      tmr_done = 1'b0; step(5);
      chk("R5 timer held", fast_mode, 1'b0);
      do_reset();
      chk("R11 timer cleared", fast_mode, 1'b1);
   endtask

   task automatic t_slope();
      do_reset();
      ticks(10);
      slope_det = 1'b1; step(1); slope_det = 1'b0; step(1);
      chk("R6 early slope ignored", fast_mode, 1'b1);
      do_reset();
      ticks(176);
      chk("R8 not yet", holdoff_done, 1'b0);
      ticks(1);
      chk("R8 done at limit", holdoff_done, 1'b1);
      ticks(5);
      chk("R8 saturated", holdoff_done, 1'b1);
      slope_det = 1'b1; step(1);
      chk("R7 slope", fast_mode, 1'b0);
      slope_det = 1'b0; step(5);
      chk("R7 slope held", fast_mode, 1'b0);
      chk("R8 trickle clears done", holdoff_done, 1'b0);
      do_reset();
      chk("R11 slope cleared", fast_mode, 1'b1);
   endtask

   task automatic t_restart();
      do_reset();
      ticks(100);
      v_low = 1'b1;
      ticks(200);
      chk("R8 no count in trickle", holdoff_done, 1'b0);
      v_low = 1'b0; step(1);
      chk("R9 back fast", fast_mode, 1'b1);
      ticks(176);
      chk("R9 restarted count", holdoff_done, 1'b0);
      ticks(1);
      chk("R9 full period", holdoff_done, 1'b1);
   endtask

   task automatic t_multi();
      do_reset();
      v_high = 1'b1; temp_cold = 1'b1; step(1);
      chk("R10 both", fast_mode, 1'b0);
      v_high = 1'b0; step(2);
      chk("R10 one left", fast_mode, 1'b0);
      temp_cold = 1'b0; step(1);
      chk("R10 all clear", fast_mode, 1'b1);
   endtask

   initial begin
      t_reset();
      t_window();
      t_cold_hot();
      t_timer();
      t_slope();
      t_restart();
      t_multi();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule